// File: doc/BRIEF.md
# PCI Legacy Interrupt Swizzle and Share Counter

This block sits at the root of one PCI bus and turns legacy INTx events from the devices below it into level messages for a downstream interrupt controller. A device reports an event with its bus number, device/function, the raw value of its interrupt pin register, a level and a pulse flag. The block rotates the pin by the device slot to pick one of four root interrupt lines. It keeps a count of asserting sources per line and, for every event, sends one message (two for a pulse) with the configured IRQ number of the line, the resulting line level and the requester ID of the source.

Events are taken one at a time on a valid/ready input. Messages leave on a valid/ready output. A small table holds one IRQ number per root line and is written through a plain configuration port. A read port returns the last recorded pin state of any device/function. A sticky flag reports any attempt to count past the limits of a line counter.

Top module: `intx_router`

## Requirements
- R1: The root line index is (P + D - 1) mod 4, where P is the low two bits of the raw pin register value `ev_pin` and D is the device number `ev_devfn[7:3]`. Device 0 therefore behaves as slot 3.
- R2: An accepted event with `ev_level`=1 or `ev_pulse`=1 increments the counter of its root line. An accepted event with both low decrements it.
- R3: `msg_level` is 1 when the counter of the message's root line is nonzero at the time the message is presented, and 0 when it is zero. A line shared by several asserting sources stays at level 1 until the last of them deasserts.
- R4: `msg_irq` is the 32-bit IRQ number configured for the message's root line. A write with `cfg_we`=1 stores `cfg_irq` for line `cfg_line` (0 = INTA … 3 = INTD) at the clock edge.
- R5: `msg_rid` equals {`ev_bus`, `ev_devfn`} of the event, with the bus in the upper byte.
- R6: A pulse event produces two messages in order. The first carries the level after the increment. The counter is then decremented, and the second message carries the level after that decrement.
- R7: `src_high` returns the pin state recorded for device/function `src_sel`. The state is set to the asserted flag (level or pulse) when an event is accepted. For a pulse, it is cleared once the first message is accepted.
- R8: A counter at its maximum ignores an increment, and a counter at zero ignores a decrement. Either attempt sets `sat_err`, which stays set until reset.
- R9: `ev_ready` is low from the cycle after an accept until the last message of that event has been accepted. A presented message holds its fields until `msg_ready` is high.
- R10: A synchronous reset (`rst`=1) clears all counters, pin states and `sat_err`, sets every IRQ number to zero, drops any pending message and leaves `ev_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | IRQ number write strobe |
| cfg_line | input | 2 | Root line whose IRQ number is written |
| cfg_irq | input | IRQ_W | IRQ number to store |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Block can accept an event |
| ev_bus | input | BUS_W | Bus number of the source |
| ev_devfn | input | DEVFN_W | Device/function of the source |
| ev_pin | input | PIN_W | Raw interrupt pin register value |
| ev_level | input | 1 | 1 = assert, 0 = deassert |
| ev_pulse | input | 1 | Pulse request: assert and then deassert |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Controller takes the message |
| msg_irq | output | IRQ_W | IRQ number of the root line |
| msg_level | output | 1 | Root line level |
| msg_rid | output | BUS_W+DEVFN_W | Requester ID {bus, devfn} |
| sat_err | output | 1 | Sticky counter limit violation |
| src_sel | input | DEVFN_W | Device/function whose pin state is read |
| src_high | output | 1 | Recorded pin state of `src_sel` |

## Verification
Two things can happen in the same cycle. The first is the decrement that follows a pulse, which coincides with the acceptance of the pulse's first message and with the clearing of the source's pin state. The second is a configuration write that lands while a message is held under back-pressure. The bench provokes both by running pulse events with `msg_ready` stalled at random, and by rewriting IRQ numbers between events on the same lines. A behavioural model that holds a queue of expected messages is compared against the ports on every clock. The model decides the level of each message and when the pin state falls, and the comparison judges both against the outputs.

// File: rtl/intx_route_pkg.sv
package intx_route_pkg;
   localparam int unsigned NUM_LINES = 4;
   localparam int unsigned LINE_W    = 2;

   typedef logic [LINE_W-1:0] line_idx_t;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_FIRST  = 2'd1,
      SEQ_SECOND = 2'd2
   } seq_state_e;
endpackage

// File: rtl/intx_swizzle.sv
module intx_swizzle
   import intx_route_pkg::*;
#(
   parameter int unsigned DEVFN_W = 8,
   parameter int unsigned PIN_W   = 8,
   parameter int unsigned DEV_LSB = 3
) (
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [PIN_W-1:0]   pin,
   output line_idx_t          line
);
   localparam int unsigned DEV_W = DEVFN_W - DEV_LSB;

   logic [DEV_W-1:0] dev_num;
   line_idx_t        slot;
   logic             unused_bits;

   assign dev_num = devfn[DEVFN_W-1:DEV_LSB];
   // slot is device number minus one, wrapping within the four lines
   assign slot    = dev_num[LINE_W-1:0] - line_idx_t'(1);
   assign line    = pin[LINE_W-1:0] + slot;

   assign unused_bits = ^{devfn[DEV_LSB-1:0], dev_num[DEV_W-1:LINE_W], pin[PIN_W-1:LINE_W]};
endmodule

// File: rtl/intx_share_ctr.sv
module intx_share_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic inc,
   input  logic dec,
   output logic nonzero,
   output logic blocked
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_max;
   logic             at_zero;

   assign at_max  = &cnt_q;
   assign at_zero = (cnt_q == '0);
   assign nonzero = !at_zero;
   assign blocked = (inc && at_max) || (dec && at_zero);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (inc && !at_max) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else if (dec && !at_zero) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/intx_irq_table.sv
module intx_irq_table
   import intx_route_pkg::*;
#(
   parameter int unsigned IRQ_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  line_idx_t        wr_idx,
   input  logic [IRQ_W-1:0] wr_data,
   input  line_idx_t        rd_idx,
   output logic [IRQ_W-1:0] rd_data
);
   logic [IRQ_W-1:0] tbl_q [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst) begin
            tbl_q[g] <= '0;
         end else if (wr_en && (wr_idx == line_idx_t'(g))) begin
            tbl_q[g] <= wr_data;
         end
      end
   end

   assign rd_data = tbl_q[rd_idx];
endmodule

// File: rtl/intx_src_state.sv
module intx_src_state #(
   parameter int unsigned DEVFN_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               set_en,
   input  logic [DEVFN_W-1:0] set_idx,
   input  logic               set_val,
   input  logic               clr_en,
   input  logic [DEVFN_W-1:0] clr_idx,
   input  logic [DEVFN_W-1:0] rd_idx,
   output logic               rd_val
);
   localparam int unsigned SRC_N = 1 << DEVFN_W;

   logic [SRC_N-1:0] state_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= '0;
      end else begin
         if (set_en) state_q[set_idx] <= set_val;
         if (clr_en) state_q[clr_idx] <= 1'b0;
      end
   end

   assign rd_val = state_q[rd_idx];
endmodule

// File: rtl/intx_router.sv
module intx_router
   import intx_route_pkg::*;
#(
   parameter int unsigned BUS_W   = 8,
   parameter int unsigned DEVFN_W = 8,
   parameter int unsigned PIN_W   = 8,
   parameter int unsigned IRQ_W   = 32,
   parameter int unsigned CNT_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_we,
   input  logic [1:0]               cfg_line,
   input  logic [IRQ_W-1:0]         cfg_irq,
   input  logic                     ev_valid,
   output logic                     ev_ready,
   input  logic [BUS_W-1:0]         ev_bus,
   input  logic [DEVFN_W-1:0]       ev_devfn,
   input  logic [PIN_W-1:0]         ev_pin,
   input  logic                     ev_level,
   input  logic                     ev_pulse,
   output logic                     msg_valid,
   input  logic                     msg_ready,
   output logic [IRQ_W-1:0]         msg_irq,
   output logic                     msg_level,
   output logic [BUS_W+DEVFN_W-1:0] msg_rid,
   output logic                     sat_err,
   input  logic [DEVFN_W-1:0]       src_sel,
   output logic                     src_high
);
   localparam int unsigned RID_W = BUS_W + DEVFN_W;

   if (DEVFN_W < 5) begin : g_bad_devfn
      $error("DEVFN_W must leave at least two device number bits");
   end
   if (PIN_W < LINE_W) begin : g_bad_pin
      $error("PIN_W must cover the line index");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (IRQ_W < 1) begin : g_bad_irq
      $error("IRQ_W must be at least 1");
   end

   seq_state_e         state_q;
   line_idx_t          line_q;
   logic [RID_W-1:0]   rid_q;
   logic [DEVFN_W-1:0] devfn_q;
   logic               pulse_q;
   logic               err_q;

   line_idx_t          line_in;
   logic               assert_in;
   logic               accept;
   logic               first_done;
   logic               pulse_drop;

   logic [NUM_LINES-1:0] inc_v;
   logic [NUM_LINES-1:0] dec_v;
   logic [NUM_LINES-1:0] nz_v;
   logic [NUM_LINES-1:0] blk_v;

   intx_swizzle #(
      .DEVFN_W (DEVFN_W),
      .PIN_W   (PIN_W),
      .DEV_LSB (3)
   ) u_swizzle (
      .devfn (ev_devfn),
      .pin   (ev_pin),
      .line  (line_in)
   );

   assign ev_ready   = (state_q == SEQ_IDLE);
   assign accept     = ev_valid && ev_ready;
   assign assert_in  = ev_level || ev_pulse;
   assign first_done = (state_q == SEQ_FIRST) && msg_ready;
   assign pulse_drop = first_done && pulse_q;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign inc_v[g] = accept && assert_in && (line_in == line_idx_t'(g));
      assign dec_v[g] = (accept && !assert_in && (line_in == line_idx_t'(g)))
                     || (pulse_drop && (line_q == line_idx_t'(g)));

      intx_share_ctr #(
         .CNT_W (CNT_W)
      ) u_ctr (
         .clk     (clk),
         .rst     (rst),
         .inc     (inc_v[g]),
         .dec     (dec_v[g]),
         .nonzero (nz_v[g]),
         .blocked (blk_v[g])
      );
   end

   intx_irq_table #(
      .IRQ_W (IRQ_W)
   ) u_irq_tbl (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we),
      .wr_idx  (line_idx_t'(cfg_line)),
      .wr_data (cfg_irq),
      .rd_idx  (line_q),
      .rd_data (msg_irq)
   );

   intx_src_state #(
      .DEVFN_W (DEVFN_W)
   ) u_src (
      .clk     (clk),
      .rst     (rst),
      .set_en  (accept),
      .set_idx (ev_devfn),
      .set_val (assert_in),
      .clr_en  (pulse_drop),
      .clr_idx (devfn_q),
      .rd_idx  (src_sel),
      .rd_val  (src_high)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         line_q  <= '0;
         rid_q   <= '0;
         devfn_q <= '0;
         pulse_q <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  state_q <= SEQ_FIRST;
                  line_q  <= line_in;
                  rid_q   <= {ev_bus, ev_devfn};
                  devfn_q <= ev_devfn;
                  pulse_q <= ev_pulse;
               end
            end
            SEQ_FIRST: begin
               if (msg_ready) state_q <= pulse_q ? SEQ_SECOND : SEQ_IDLE;
            end
            SEQ_SECOND: begin
               if (msg_ready) state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= err_q || (|blk_v);
   end

   assign msg_valid = (state_q != SEQ_IDLE);
   assign msg_level = nz_v[line_q];
   assign msg_rid   = rid_q;
   assign sat_err   = err_q;
endmodule

// File: rtl/intx_router_chk.sv
module intx_router_chk #(
   parameter int unsigned IRQ_W = 32,
   parameter int unsigned RID_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             cfg_we,
   input logic             ev_valid,
   input logic             ev_ready,
   input logic             msg_valid,
   input logic             msg_ready,
   input logic [IRQ_W-1:0] msg_irq,
   input logic             msg_level,
   input logic [RID_W-1:0] msg_rid,
   input logic             sat_err
);
   AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (msg_valid && !msg_ready && !cfg_we) |=> (msg_valid && $stable(msg_irq)
                                                && $stable(msg_rid) && $stable(msg_level))); // R9

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> !ev_ready); // R9

   AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_ready) |=> msg_valid); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      sat_err |=> sat_err); // R8

   AST_RESET_CLEAN: assert property (@(posedge clk)
      rst |=> (!msg_valid && !sat_err && ev_ready)); // R10
endmodule

bind intx_router intx_router_chk #(
   .IRQ_W (IRQ_W),
   .RID_W (BUS_W + DEVFN_W)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_we    (cfg_we),
   .ev_valid  (ev_valid),
   .ev_ready  (ev_ready),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_irq   (msg_irq),
   .msg_level (msg_level),
   .msg_rid   (msg_rid),
   .sat_err   (sat_err)
);

// File: tb/test_intx_router.sv
`timescale 1ns/1ps
module test_intx_router;
   localparam int CNT_W = 3;
   localparam int MAXC  = (1 << CNT_W) - 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_line = '0;
   logic [31:0] cfg_irq = '0;
   logic        ev_valid = 1'b0;
   logic        ev_ready;
   logic [7:0]  ev_bus = '0;
   logic [7:0]  ev_devfn = '0;
   logic [7:0]  ev_pin = '0;
   logic        ev_level = 1'b0;
   logic        ev_pulse = 1'b0;
   logic        msg_valid;
   logic        msg_ready = 1'b1;
   logic [31:0] msg_irq;
   logic        msg_level;
   logic [15:0] msg_rid;
   logic        sat_err;
   logic [7:0]  src_sel = '0;
   logic        src_high;

   always #2.5 clk = ~clk;

   intx_router #(
      .BUS_W (8), .DEVFN_W (8), .PIN_W (8), .IRQ_W (32), .CNT_W (CNT_W)
   ) i_intx_router (
      .clk (clk), .rst (rst),
      .cfg_we (cfg_we), .cfg_line (cfg_line), .cfg_irq (cfg_irq),
      .ev_valid (ev_valid), .ev_ready (ev_ready), .ev_bus (ev_bus),
      .ev_devfn (ev_devfn), .ev_pin (ev_pin), .ev_level (ev_level),
      .ev_pulse (ev_pulse),
      .msg_valid (msg_valid), .msg_ready (msg_ready), .msg_irq (msg_irq),
      .msg_level (msg_level), .msg_rid (msg_rid),
      .sat_err (sat_err), .src_sel (src_sel), .src_high (src_high)
   );

   typedef struct {
      int          line;
      bit          lvl;
      logic [15:0] rid;
      bit          clr;
      logic [7:0]  devfn;
   } exp_t;

   exp_t        q[$];
   int          m_cnt [4];
   logic [31:0] m_irq [4];
   bit          m_src [256];
   bit          m_err;
   bit          armed = 1'b0;
   bit          stall_on = 1'b0;
   int          n_cmp = 0;
   int          n_bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      armed = 1'b1;
      if (rst) begin
         for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_irq[i] = '0; end
         for (int i = 0; i < 256; i++) m_src[i] = 1'b0;
         m_err = 1'b0;
         q.delete();
      end else begin
         if (cfg_we) m_irq[cfg_line] = cfg_irq;
         if (q.size() != 0) begin
            if (msg_ready) begin
               if (q[0].clr) m_src[q[0].devfn] = 1'b0;
               void'(q.pop_front());
            end
         end else if (ev_valid) begin
            int  ln;
            bit  up;
            exp_t e;
            ln = (int'(ev_pin) % 4 + int'(ev_devfn) / 8 + 3) % 4;
            up = ev_level || ev_pulse;
            if (up) begin
               if (m_cnt[ln] == MAXC) m_err = 1'b1; else m_cnt[ln]++;
            end else begin
               if (m_cnt[ln] == 0) m_err = 1'b1; else m_cnt[ln]--;
            end
            e.line = ln; e.lvl = (m_cnt[ln] != 0); e.rid = {ev_bus, ev_devfn};
            e.clr = ev_pulse; e.devfn = ev_devfn;
            q.push_back(e);
            m_src[ev_devfn] = up;
            if (ev_pulse) begin
               if (m_cnt[ln] == 0) m_err = 1'b1; else m_cnt[ln]--;
               e.lvl = (m_cnt[ln] != 0); e.clr = 1'b0;
               q.push_back(e);
            end
         end
      end
   end

   // per-clock comparison, away from the edge
   always @(negedge clk) begin
      #1;
      if (armed) begin
         chk("R9 ev_ready", ev_ready, q.size() == 0);
         chk("R6 R9 msg_valid", msg_valid, q.size() != 0);
         if (q.size() != 0 && msg_valid) begin
            chk("R1 R4 msg_irq", msg_irq, m_irq[q[0].line]);
            chk("R2 R3 msg_level", msg_level, q[0].lvl);
            chk("R5 msg_rid", msg_rid, q[0].rid);
         end
         chk("R8 sat_err", sat_err, m_err);
         chk("R7 src_high", src_high, m_src[src_sel]);
      end
   end

   always @(negedge clk) begin
      msg_ready = stall_on ? ($urandom_range(0, 2) != 0) : 1'b1;
   end

   task automatic post(input logic [7:0] b, input logic [7:0] d, input logic [7:0] p,
                       input bit lv, input bit pl);
      @(negedge clk);
      ev_valid = 1'b1; ev_bus = b; ev_devfn = d; ev_pin = p;
      ev_level = lv; ev_pulse = pl; src_sel = d;
      while (!ev_ready) @(negedge clk);
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic set_irq(input int ln, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_line = ln[1:0]; cfg_irq = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R10 ev_ready after reset", ev_ready, 1'b1);
      chk("R10 msg_valid after reset", msg_valid, 1'b0);
      chk("R10 sat_err after reset", sat_err, 1'b0);
      chk("R10 src_high after reset", src_high, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      for (int i = 0; i < 4; i++) set_irq(i, 32'hA000_0010 + 32'(i * 17));

      // R1: every device/pin combination, assert then deassert
      for (int d = 0; d < 6; d++)
         for (int p = 0; p < 5; p++) begin
            post(8'h3C, 8'(d * 8 + (p % 3)), 8'(p), 1'b1, 1'b0);
            post(8'h3C, 8'(d * 8 + (p % 3)), 8'(p), 1'b0, 1'b0);
         end
      drain();

      // R3: sharing, dev1 pin0 and dev2 pin3 both land on line 0
      post(8'h01, 8'h08, 8'd0, 1'b1, 1'b0);
      post(8'h01, 8'h10, 8'd3, 1'b1, 1'b0);
      post(8'h01, 8'h08, 8'd0, 1'b0, 1'b0);
      post(8'h01, 8'h10, 8'd3, 1'b0, 1'b0);
      drain();

      // R6 R7: pulses with back-pressure, also onto a line already high
      stall_on = 1'b1;
      post(8'h02, 8'h19, 8'd1, 1'b0, 1'b1);
      post(8'h02, 8'h20, 8'd2, 1'b1, 1'b0);
      post(8'h02, 8'h28, 8'd1, 1'b1, 1'b1);
      post(8'hFF, 8'h07, 8'd2, 1'b1, 1'b1);
      // R4: rewrite IRQ numbers between events
      set_irq(1, 32'hDEAD_0001);
      set_irq(3, 32'hFFFF_FFFF);
      post(8'h05, 8'h20, 8'd2, 1'b0, 1'b0);
      post(8'h05, 8'h31, 8'd0, 1'b0, 1'b1);
      drain();

      // R8: overflow on line 2 then underflow
      stall_on = 1'b0;
      for (int k = 0; k < MAXC + 2; k++) post(8'h09, 8'h18, 8'd0, 1'b1, 1'b0);
      post(8'h09, 8'h18, 8'd0, 1'b1, 1'b1);
      for (int k = 0; k < MAXC + 2; k++) post(8'h09, 8'h18, 8'd0, 1'b0, 1'b0);
      drain();

      // R10: reset in the middle of a stalled message, then irq table is zero
      stall_on = 1'b1;
      post(8'h0A, 8'h08, 8'd1, 1'b1, 1'b1);
      do_reset();
      stall_on = 1'b0;
      post(8'h0B, 8'h08, 8'd1, 1'b1, 1'b0);
      post(8'h0B, 8'h08, 8'd1, 1'b0, 1'b0);
      drain();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule